// File: doc/BRIEF.md
# Command Set Sequencer

This block stores a number of command sets, each with up to `NCMD` slots. Every slot holds a 32-bit target address, 32-bit data and a wait flag. Software loads the slots and a per-set valid mask through a simple write port. When a set is triggered, the block issues the occupied slots one by one over a valid/ready request bus toward resource accelerators. A command whose wait flag is set stalls the sequence until a response tagged with that set and slot comes back. When the last command of a set completes, the set's busy bit drops and its interrupt bit rises. The interrupt bit stays high until software clears it.

Sets are grouped by power-state type. Set indices are laid out in type-code order: sleep sets (type 0) come first, then wake (1), then active (2), then control (3). Only active sets answer the software trigger. Sleep, wake and control sets answer the firmware trigger that fires once the processors are powered down. When the block is built with no active sets, wake sets also accept the software trigger, so immediate requests still have a path. Busy sets are served one at a time, lowest index first.

Top module: `cmd_set_seq`

## Requirements
- R1: After reset, `busy`, `irq` and `req_valid` are all zero.
- R2: A triggered set issues only the slots whose valid-mask bit is 1, in ascending slot order, and `req_addr`, `req_data`, `req_set` and `req_idx` hold steady while `req_valid` is high and `req_ready` is low.
- R3: After a command with its wait flag set is accepted, no further request is issued until `rsp_valid` arrives with `rsp_set` and `rsp_idx` equal to that command's set and slot; responses carrying any other tag are ignored.
- R4: An accepted trigger raises the set's `busy` bit at the next clock edge. `busy` clears, and the set's `irq` bit rises, one edge after the last command is accepted, or one edge after its matching response if that command carries a wait flag.
- R5: An `irq` bit stays high until the matching `irq_clr` bit is driven; a new completion in the same cycle takes priority over the clear.
- R6: `sw_trig` is accepted only for active sets, and `fw_trig` only for sleep, wake and control sets; any other trigger leaves `busy` unchanged.
- R7: When `N_ACTIVE` is 0, `sw_trig` is also accepted for wake sets.
- R8: A trigger for a set that is already busy is ignored and does not queue a second run. A trigger for a set whose valid mask is all zero is ignored, and software invalidates a set by writing a zero mask.
- R9: Slot writes (`cfg_we`) and mask writes (`mask_we`) aimed at a busy set are ignored.
- R10: When several sets are busy, the set with the lowest index is sequenced first, and each set runs to completion before the next one starts.
- R11: Each request carries the stored address and data unchanged, including the target id in address bits [18:16] and the register offset in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one command slot |
| cfg_set | input | SW | Set index for the slot write |
| cfg_idx | input | CW | Slot index for the slot write |
| cfg_addr | input | 32 | Command address |
| cfg_data | input | 32 | Command data |
| cfg_wait | input | 1 | Command wait flag |
| mask_we | input | 1 | Write a set's valid mask |
| mask_set | input | SW | Set index for the mask write |
| mask_val | input | NCMD | New valid mask, bit i marks slot i occupied |
| sw_trig | input | 1 | Software trigger pulse |
| sw_set | input | SW | Set index for the software trigger |
| fw_trig | input | 1 | Firmware trigger pulse |
| fw_set | input | SW | Set index for the firmware trigger |
| irq_clr | input | NSETS | Per-set interrupt clear |
| busy | output | NSETS | Per-set busy flag |
| irq | output | NSETS | Per-set level completion interrupt |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_addr | output | 32 | Command address |
| req_data | output | 32 | Command data |
| req_wait | output | 1 | Command expects a response before the next one |
| req_set | output | SW | Set the command comes from |
| req_idx | output | CW | Slot the command comes from |
| rsp_valid | input | 1 | Response pulse |
| rsp_set | input | SW | Set tag of the response |
| rsp_idx | input | CW | Slot tag of the response |

## Verification
The main instance is built with four slots per set and one sleep, two wake, one active and one control set. This keeps the last slot, a full mask, a sparse mask and every type in reach of short directed sequences. A second instance with no active sets shares the same stimulus, so the wake-set fallback for the software trigger is checked against the normal layout, where the same trigger must be refused. Holding `req_ready` low makes the busy-set write blocking, the repeat-trigger case and the lowest-index ordering observable at the ports.

// File: rtl/cmd_set_seq.sv
module cmd_set_seq #(
  parameter int NCMD     = 16,
  parameter int N_SLEEP  = 3,
  parameter int N_WAKE   = 3,
  parameter int N_ACTIVE = 2,
  parameter int N_CTRL   = 1,
  localparam int NSETS   = N_SLEEP + N_WAKE + N_ACTIVE + N_CTRL,
  localparam int SW      = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int CW      = (NCMD > 1) ? $clog2(NCMD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_set,
  input  logic [CW-1:0]    cfg_idx,
  input  logic [31:0]      cfg_addr,
  input  logic [31:0]      cfg_data,
  input  logic             cfg_wait,
  input  logic             mask_we,
  input  logic [SW-1:0]    mask_set,
  input  logic [NCMD-1:0]  mask_val,
  input  logic             sw_trig,
  input  logic [SW-1:0]    sw_set,
  input  logic             fw_trig,
  input  logic [SW-1:0]    fw_set,
  input  logic [NSETS-1:0] irq_clr,
  output logic [NSETS-1:0] busy,
  output logic [NSETS-1:0] irq,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_addr,
  output logic [31:0]      req_data,
  output logic             req_wait,
  output logic [SW-1:0]    req_set,
  output logic [CW-1:0]    req_idx,
  input  logic             rsp_valid,
  input  logic [SW-1:0]    rsp_set,
  input  logic [CW-1:0]    rsp_idx
);

  localparam logic [1:0] TY_WAKE = 2'd1, TY_ACT = 2'd2;

  function automatic logic [1:0] set_type(input int s);
    if (s < N_SLEEP) return 2'd0;
    if (s < N_SLEEP + N_WAKE) return 2'd1;
    if (s < N_SLEEP + N_WAKE + N_ACTIVE) return 2'd2;
    return 2'd3;
  endfunction

  logic [31:0]     slot_addr [NSETS][NCMD];
  logic [31:0]     slot_data [NSETS][NCMD];
  logic [NCMD-1:0] slot_wait [NSETS];
  logic [NCMD-1:0] vmask     [NSETS];
  logic [NSETS-1:0] busy_q, irq_q;
  logic            run, waiting;
  logic [SW-1:0]   cur, nxt;
  logic [CW-1:0]   pick, widx;
  logic [NCMD-1:0] rem;
  logic            sw_ok, fw_ok, done, rsp_hit;
  logic [1:0]      sw_ty, fw_ty;

  always_comb begin
    pick = '0;
    for (int i = NCMD - 1; i >= 0; i--) if (rem[i]) pick = CW'(i);
  end

  always_comb begin
    nxt = '0;
    for (int s = NSETS - 1; s >= 0; s--) if (busy_q[s]) nxt = SW'(s);
  end

  assign sw_ty = set_type(int'(sw_set));
  assign fw_ty = set_type(int'(fw_set));
  assign sw_ok = sw_trig && int'(sw_set) < NSETS && !busy_q[sw_set] && |vmask[sw_set]
                 && (sw_ty == TY_ACT || (N_ACTIVE == 0 && sw_ty == TY_WAKE));
  assign fw_ok = fw_trig && int'(fw_set) < NSETS && !busy_q[fw_set] && |vmask[fw_set]
                 && fw_ty != TY_ACT;

  assign req_valid = run && !waiting && |rem;
  assign req_addr  = slot_addr[cur][pick];
  assign req_data  = slot_data[cur][pick];
  assign req_wait  = slot_wait[cur][pick];
  assign req_set   = cur;
  assign req_idx   = pick;
  assign done      = run && !waiting && rem == '0;
  assign rsp_hit   = waiting && rsp_valid && rsp_set == cur && rsp_idx == widx;
  assign busy      = busy_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (cfg_we && int'(cfg_set) < NSETS && !busy_q[cfg_set]) begin
      slot_addr[cfg_set][cfg_idx] <= cfg_addr;
      slot_data[cfg_set][cfg_idx] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        slot_wait[s] <= '0;
        vmask[s]     <= '0;
      end
    end else begin
      if (cfg_we && int'(cfg_set) < NSETS && !busy_q[cfg_set])
        slot_wait[cfg_set][cfg_idx] <= cfg_wait;
      if (mask_we && int'(mask_set) < NSETS && !busy_q[mask_set])
        vmask[mask_set] <= mask_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      waiting <= 1'b0;
      cur     <= '0;
      widx    <= '0;
      rem     <= '0;
      busy_q  <= '0;
      irq_q   <= '0;
    end else begin
      if (!run) begin
        if (|busy_q) begin
          run     <= 1'b1;
          cur     <= nxt;
          rem     <= vmask[nxt];
          waiting <= 1'b0;
        end
      end else if (waiting) begin
        if (rsp_hit) waiting <= 1'b0;
      end else if (rem == '0) begin
        run <= 1'b0;
      end else if (req_ready) begin
        rem[pick] <= 1'b0;
        if (slot_wait[cur][pick]) begin
          waiting <= 1'b1;
          widx    <= pick;
        end
      end
      for (int s = 0; s < NSETS; s++) begin
        if (done && cur == SW'(s))
          busy_q[s] <= 1'b0;
        else if ((sw_ok && sw_set == SW'(s)) || (fw_ok && fw_set == SW'(s)))
          busy_q[s] <= 1'b1;
        if (done && cur == SW'(s))
          irq_q[s] <= 1'b1;
        else if (irq_clr[s])
          irq_q[s] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmd_set_seq_chk.sv
module cmd_set_seq_chk #(
  parameter int NSETS = 4,
  parameter int NCMD  = 16,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int CW   = (NCMD > 1) ? $clog2(NCMD) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_trig,
  input logic             fw_trig,
  input logic [NSETS-1:0] busy,
  input logic [NSETS-1:0] irq,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_addr,
  input logic [31:0]      req_data,
  input logic [SW-1:0]    req_set,
  input logic [CW-1:0]    req_idx
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
      && $stable(req_set) && $stable(req_idx));

  // R10
  req_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy[req_set]);

  genvar g;
  for (g = 0; g < NSETS; g++) begin : g_set
    // R4
    irq_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> $fell(busy[g]));
    // R6
    busy_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[g]) |-> $past(sw_trig || fw_trig));
  end

endmodule

bind cmd_set_seq cmd_set_seq_chk #(.NSETS(NSETS), .NCMD(NCMD)) u_chk (.*);

// File: tb/cmd_set_seq_bench.sv
module cmd_set_seq_bench;
  localparam int NCMD = 4;
  localparam int NS = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_wait = 0, mask_we = 0, sw_trig = 0, fw_trig = 0;
  logic [2:0] cfg_set = 0, mask_set = 0, sw_set = 0, fw_set = 0;
  logic [1:0] cfg_idx = 0;
  logic [31:0] cfg_addr = 0, cfg_data = 0;
  logic [NCMD-1:0] mask_val = 0;
  logic [NS-1:0] irq_clr = 0;
  logic [NS-1:0] busy, irq;
  logic req_valid, req_ready = 0, req_wait;
  logic [31:0] req_addr, req_data;
  logic [2:0] req_set;
  logic [1:0] req_idx;
  logic rsp_valid = 0;
  logic [2:0] rsp_set = 0;
  logic [1:0] rsp_idx = 0;

  logic [3:0] busy2, irq2;
  logic rv2, rw2;
  logic [31:0] ra2, rd2;
  logic [1:0] rs2, ri2;

  int nchk = 0, nfail = 0, hs_n = 0;
  logic [31:0] hs_addr [128];
  logic [31:0] hs_data [128];
  logic [2:0]  hs_set  [128];
  logic [1:0]  hs_idx  [128];
  bit fin = 0;

  always #5 clk = ~clk;

  cmd_set_seq #(.NCMD(NCMD), .N_SLEEP(1), .N_WAKE(2), .N_ACTIVE(1), .N_CTRL(1)) u_cmd_set_seq (
    .clk, .rst_n, .cfg_we, .cfg_set, .cfg_idx, .cfg_addr, .cfg_data, .cfg_wait,
    .mask_we, .mask_set, .mask_val, .sw_trig, .sw_set, .fw_trig, .fw_set, .irq_clr,
    .busy, .irq, .req_valid, .req_ready, .req_addr, .req_data, .req_wait, .req_set,
    .req_idx, .rsp_valid, .rsp_set, .rsp_idx);

  cmd_set_seq #(.NCMD(NCMD), .N_SLEEP(1), .N_WAKE(2), .N_ACTIVE(0), .N_CTRL(1)) u_cmd_set_seq_noact (
    .clk, .rst_n, .cfg_we, .cfg_set(cfg_set[1:0]), .cfg_idx, .cfg_addr, .cfg_data, .cfg_wait,
    .mask_we, .mask_set(mask_set[1:0]), .mask_val, .sw_trig, .sw_set(sw_set[1:0]),
    .fw_trig, .fw_set(fw_set[1:0]), .irq_clr(irq_clr[3:0]), .busy(busy2), .irq(irq2),
    .req_valid(rv2), .req_ready(1'b1), .req_addr(ra2), .req_data(rd2), .req_wait(rw2),
    .req_set(rs2), .req_idx(ri2), .rsp_valid(1'b0), .rsp_set(2'd0), .rsp_idx(2'd0));

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && hs_n < 128) begin
      hs_addr[hs_n] = req_addr;
      hs_data[hs_n] = req_data;
      hs_set[hs_n]  = req_set;
      hs_idx[hs_n]  = req_idx;
      hs_n++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr_cmd(int s, int i, logic [31:0] a, logic [31:0] d, logic w);
    cfg_we = 1; cfg_set = 3'(s); cfg_idx = 2'(i); cfg_addr = a; cfg_data = d; cfg_wait = w;
    tick();
    cfg_we = 0;
  endtask

  task automatic wr_mask(int s, logic [NCMD-1:0] m);
    mask_we = 1; mask_set = 3'(s); mask_val = m;
    tick();
    mask_we = 0;
  endtask

  task automatic trig_sw(int s);
    sw_trig = 1; sw_set = 3'(s);
    tick();
    sw_trig = 0;
  endtask

  task automatic trig_fw(int s);
    fw_trig = 1; fw_set = 3'(s);
    tick();
    fw_trig = 0;
  endtask

  task automatic wait_free();
    for (int k = 0; k < 200 && busy != 0; k++) tick();
  endtask

  task automatic wait_hs(int n);
    for (int k = 0; k < 200 && hs_n < n; k++) tick();
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req_valid", 32'(req_valid), 0);
  endtask

  task automatic t_order();
    int b;
    for (int i = 0; i < 4; i++) wr_cmd(3, i, 32'h0003_0000 | (i << 4), 32'hA0 + i, 0);
    wr_mask(3, 4'b1011);
    req_ready = 0;
    b = hs_n;
    trig_sw(3);
    chk("R4 busy on trigger", 32'(busy[3]), 1);
    repeat (4) tick();
    chk("R2 held valid", 32'(req_valid), 1);
    chk("R2 held idx", 32'(req_idx), 0);
    chk("R11 held addr", req_addr, 32'h0003_0000);
    req_ready = 1;
    wait_free();
    chk("R2 count", hs_n - b, 3);
    chk("R2 order", {hs_idx[b], hs_idx[b+1], hs_idx[b+2]}, {2'd0, 2'd1, 2'd3});
    chk("R11 addr", hs_addr[b+1], 32'h0003_0010);
    chk("R11 data", hs_data[b+2], 32'hA3);
    chk("R2 set tag", 32'(hs_set[b]), 3);
    chk("R4 irq at done", 32'(irq[3]), 1);
  endtask

  task automatic t_irq();
    repeat (3) tick();
    chk("R5 irq level", 32'(irq[3]), 1);
    irq_clr = 5'b01000;
    tick();
    irq_clr = 0;
    chk("R5 irq cleared", 32'(irq[3]), 0);
  endtask

  task automatic t_wait();
    int b;
    wr_cmd(3, 0, 32'h0001_0100, 32'h11, 1);
    wr_cmd(3, 1, 32'h0001_0104, 32'h22, 1);
    wr_mask(3, 4'b0011);
    req_ready = 1;
    b = hs_n;
    trig_sw(3);
    wait_hs(b + 1);
    repeat (3) tick();
    chk("R3 stall", 32'(req_valid), 0);
    rsp_valid = 1; rsp_set = 3; rsp_idx = 1;
    tick();
    rsp_valid = 0;
    tick();
    chk("R3 wrong tag ignored", 32'(req_valid), 0);
    chk("R3 no extra hs", hs_n - b, 1);
    rsp_valid = 1; rsp_idx = 0;
    tick();
    rsp_valid = 0;
    wait_hs(b + 2);
    repeat (3) tick();
    chk("R4 busy until last rsp", 32'(busy[3]), 1);
    rsp_valid = 1; rsp_idx = 1;
    tick();
    rsp_valid = 0;
    tick();
    chk("R4 busy cleared", 32'(busy[3]), 0);
    chk("R4 irq after rsp", 32'(irq[3]), 1);
    irq_clr = 5'b01000;
    tick();
    irq_clr = 0;
    wr_cmd(3, 0, 32'h0001_0100, 32'h11, 0);
    wr_cmd(3, 1, 32'h0001_0104, 32'h22, 0);
  endtask

  task automatic t_types();
    int b;
    for (int i = 0; i < 4; i++) wr_cmd(0, i, 32'h0002_0000 | i, 32'hB0 + i, 0);
    wr_mask(0, 4'b1111);
    trig_sw(0);
    chk("R6 sw on sleep ignored", 32'(busy[0]), 0);
    trig_fw(3);
    chk("R6 fw on active ignored", 32'(busy[3]), 0);
    b = hs_n;
    trig_fw(0);
    chk("R6 fw on sleep", 32'(busy[0]), 1);
    wait_free();
    chk("R6 sleep ran", hs_n - b, 4);
    wr_cmd(4, 0, 32'h0004_0008, 32'hC0, 0);
    wr_mask(4, 4'b0001);
    b = hs_n;
    trig_fw(4);
    chk("R6 fw on control", 32'(busy[4]), 1);
    wait_free();
    chk("R6 control set tag", 32'(hs_set[b]), 4);
  endtask

  task automatic t_busy();
    int b;
    req_ready = 0;
    b = hs_n;
    trig_fw(0);
    trig_fw(0);
    wr_cmd(0, 2, 32'hDEAD_0000, 32'h0, 0);
    wr_mask(0, 4'b0001);
    req_ready = 1;
    wait_free();
    repeat (6) tick();
    chk("R8 single run", hs_n - b, 4);
    chk("R9 slot write blocked", hs_addr[b+2], 32'h0002_0002);
    chk("R8 no requeue", 32'(busy), 0);
  endtask

  task automatic t_invalid();
    int b;
    wr_mask(2, 4'b0001);
    wr_mask(2, 4'b0000);
    b = hs_n;
    trig_fw(2);
    chk("R8 empty mask ignored", 32'(busy[2]), 0);
    repeat (2) tick();
    chk("R8 no irq", 32'(irq[2]), 0);
    chk("R8 no hs", hs_n - b, 0);
  endtask

  task automatic t_prio();
    int b;
    req_ready = 0;
    b = hs_n;
    sw_trig = 1; sw_set = 3; fw_trig = 1; fw_set = 0;
    tick();
    sw_trig = 0; fw_trig = 0;
    chk("R10 both busy", 32'({busy[3], busy[0]}), 32'b11);
    req_ready = 1;
    wait_free();
    chk("R10 total", hs_n - b, 6);
    chk("R10 low first", 32'(hs_set[b]), 0);
    chk("R10 then active", 32'(hs_set[b+4]), 3);
  endtask

  task automatic t_noact();
    wait_free();
    for (int k = 0; k < 50 && busy2 != 0; k++) tick();
    wr_cmd(1, 0, 32'h0005_0000, 32'hD0, 0);
    wr_mask(1, 4'b0001);
    trig_sw(1);
    chk("R6 sw on wake refused", 32'(busy[1]), 0);
    chk("R7 sw on wake accepted", 32'(busy2[1]), 1);
    for (int k = 0; k < 50 && busy2 != 0; k++) tick();
    chk("R7 wake irq", 32'(irq2[1]), 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_irq();
    t_wait();
    t_types();
    t_busy();
    t_invalid();
    t_prio();
    t_noact();
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!fin) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule